// File: doc/BRIEF.md
# CRC-16 Custom Instruction Unit

This unit sits next to a processor ALU and serves a single custom opcode that computes a 16-bit CRC. Each issue of the opcode brings one 16-bit operand and a one-bit mode selector. The unit answers with one 16-bit result, which is the CRC register as it stands once the operation ends. A `done` pulse tells the pipeline when it may stop stalling and take the result.

Software seeds the register with a seed issue, for example 0xFFFF for the common CCITT start value. It then issues one fold for each 16-bit message word. A fold pushes the word into the running remainder one bit per clock, most significant bit first, using the generator polynomial 0x1021. The register carries over from one issue to the next, so a message of any length is covered by a sequence of folds. The unit never touches memory or the bus.

Top module: `crc16_ci`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `result` is 0x0000 and `done` is low.
- R2: A seed issue (`start`=1, `mode`=1, unit idle) copies `operand` into the CRC register. `result` shows the operand and `done` is high in the cycle that follows the sampling edge.
- R3: A fold issue (`start`=1, `mode`=0, unit idle) does one bit step per clock. `done` is high in the cycle that follows the 17th rising edge, counting the edge that sampled `start` as the first.
- R4: A fold updates the register as follows. The incoming word is XORed into the 16-bit register, then 16 steps run. In each step the register shifts left by one, and it is XORed with 0x1021 when the bit shifted out was 1. The result carries into the next fold.
- R5: `done` stays high for exactly one cycle unless a new seed issue is accepted in that same cycle.
- R6: A `start` presented while a fold is in progress is ignored. It does not change the finished result or the latency of the fold.
- R7: `result` holds its previous value until the edge that raises `done`.
- R8: While `start` is low, changes on `mode` and `operand` change neither `result` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue request for one operation |
| mode | input | 1 | 1 = seed the register, 0 = fold a word |
| operand | input | 16 | Seed value or message word |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Current CRC value |

## Verification
The bench builds the unit with its default parameters: a 16-bit data width and the polynomial 0x1021. With these values the fold latency and the remainder can be predicted by a word-level division written independently in the bench. Random sequences of seed and fold issues, with seeds mixed in, check that the remainder carries correctly across long chains of words. Directed cases cover all-zero and single-high-bit words, a `start` injected in the middle of a fold, and idle cycles in which `mode` and `operand` toggle with `start` low.

// File: rtl/crc16_ci_pkg.sv
package crc16_ci_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } ci_state_e;

  localparam logic MODE_FOLD = 1'b0;
  localparam logic MODE_SEED = 1'b1;

endpackage

// File: rtl/crc16_ci_ctrl.sv
module crc16_ci_ctrl
  import crc16_ci_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mode,
  output logic accept_seed,
  output logic accept_fold,
  output logic busy,
  output logic step,
  output logic last_step,
  output logic done
);

  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  ci_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             idle;

  assign idle        = (state_q == ST_IDLE);
  assign accept_seed = start && idle && (mode == MODE_SEED);
  assign accept_fold = start && idle && (mode == MODE_FOLD);
  assign busy        = (state_q == ST_SHIFT);
  assign step        = busy;
  assign last_step   = busy && (cnt_q == LAST_IDX);
  assign done        = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= accept_seed | last_step;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_fold) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_SHIFT: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crc16_ci_datapath.sv
module crc16_ci_datapath #(
  parameter int unsigned          DATA_W = 16,
  parameter logic [DATA_W-1:0]    POLY   = DATA_W'(16'h1021)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_seed,
  input  logic              load_word,
  input  logic              step,
  input  logic              last_step,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);

  // One serial division step: the feedback is the bit leaving the top
  // of the register combined with the incoming message bit.
  function automatic logic [DATA_W-1:0] fold_bit(
    input logic [DATA_W-1:0] crc,
    input logic              din
  );
    logic fb;
    fb = crc[DATA_W-1] ^ din;
    return {crc[DATA_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  logic [DATA_W-1:0] work_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] work_next;

  assign work_next = fold_bit(work_q, data_q[DATA_W-1]);
  assign result    = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      data_q <= '0;
      res_q  <= '0;
    end else if (load_seed) begin
      work_q <= operand;
      res_q  <= operand;
    end else if (load_word) begin
      data_q <= operand;
    end else if (step) begin
      work_q <= work_next;
      data_q <= {data_q[DATA_W-2:0], 1'b0};
      if (last_step) begin
        res_q <= work_next;
      end
    end
  end

endmodule

// File: rtl/crc16_ci.sv
module crc16_ci #(
  parameter int unsigned       DATA_W = 16,
  parameter logic [DATA_W-1:0] POLY   = DATA_W'(16'h1021)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode,
  input  logic [DATA_W-1:0] operand,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  logic accept_seed;
  logic accept_fold;
  logic accept;
  logic busy;
  logic step;
  logic last_step;

  assign accept = accept_seed | accept_fold;

  crc16_ci_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mode        (mode),
    .accept_seed (accept_seed),
    .accept_fold (accept_fold),
    .busy        (busy),
    .step        (step),
    .last_step   (last_step),
    .done        (done)
  );

  crc16_ci_datapath #(
    .DATA_W (DATA_W),
    .POLY   (POLY)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load_seed (accept_seed),
    .load_word (accept_fold),
    .step      (step),
    .last_step (last_step),
    .operand   (operand),
    .result    (result)
  );

endmodule

// File: rtl/crc16_ci_chk.sv
module crc16_ci_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mode,
  input logic [DATA_W-1:0] operand,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              accept,
  input logic              accept_fold,
  input logic              busy,
  input logic              step,
  input logic              last_step
);

  localparam int unsigned CW = $clog2(DATA_W + 1);

  logic [CW-1:0] steps_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      steps_q <= '0;
    end else if (accept_fold) begin
      steps_q <= '0;
    end else if (step) begin
      steps_q <= steps_q + 1'b1;
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !done));

  // R2
  a_r2_seed_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (start && mode && !busy) |=> (done && result == $past(operand)));

  // R3
  a_r3_step_count: assert property (@(posedge clk) disable iff (rst)
    last_step |-> (steps_q == CW'(DATA_W - 1)));

  // R3
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
    last_step |=> done);

  // R5
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);

  // R7
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

bind crc16_ci crc16_ci_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .mode        (mode),
  .operand     (operand),
  .done        (done),
  .result      (result),
  .accept      (accept),
  .accept_fold (accept_fold),
  .busy        (busy),
  .step        (step),
  .last_step   (last_step)
);

// File: tb/crc16_ci_bench.sv
module crc16_ci_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] operand = '0;
  logic        done;
  logic [15:0] result;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_ci u_crc16_ci (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mode    (mode),
    .operand (operand),
    .done    (done),
    .result  (result)
  );

  // Word-level long division: XOR the word in, then 16 top-bit tests.
  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c ^ w;
    for (int i = 0; i < 16; i++) begin
      if (r[15]) r = (r << 1) ^ 16'h1021;
      else       r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Issue one operation; optionally poke start while busy (R6).
  task automatic issue(input logic m, input logic [15:0] op, input bit poke);
    logic [15:0] prev;
    int lat;
    bit got;
    bit held;
    prev = result;
    held = 1'b1;
    got  = 1'b0;
    lat  = 0;
    @(negedge clk);
    start = 1'b1; mode = m; operand = op;
    while (!got && lat < 64) begin
      @(negedge clk);
      lat++;
      if (lat == 1) start = 1'b0;
      if (poke && lat == 3) begin
        start = 1'b1; mode = 1'($urandom); operand = 16'($urandom);
      end
      if (poke && lat == 4) start = 1'b0;
      if (done) got = 1'b1;
      else if (result !== prev) held = 1'b0;
    end
    chk("R7", "result held while busy", int'(held), 1);
    if (!got) begin
      chk("R3", "done timeout", 0, 1);
    end else begin
      model = m ? op : ref_fold(model, op);
      if (m) chk("R2", "seed latency", lat, 1);
      else   chk(poke ? "R6" : "R3", "fold latency", lat, 17);
      chk(m ? "R2" : (poke ? "R6" : "R4"), "result", int'(result), int'(model));
    end
    @(negedge clk);
    chk("R5", "done one cycle", int'(done), 0);
    chk("R5", "result after done", int'(result), int'(model));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "result in reset", int'(result), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "result after reset", int'(result), 0);
    chk("R1", "done after reset", int'(done), 0);

    // R4: zero word into zero register stays zero
    issue(1'b0, 16'h0000, 1'b0);
    // R4: single high bit
    issue(1'b0, 16'h8000, 1'b0);
    issue(1'b0, 16'h0001, 1'b0);
    // R2: standard seed then folds
    issue(1'b1, 16'hFFFF, 1'b0);
    issue(1'b0, 16'h3132, 1'b0);
    issue(1'b0, 16'hFFFF, 1'b0);
    // R6: start during a fold
    issue(1'b0, 16'hA5C3, 1'b1);
    issue(1'b0, 16'h0F0F, 1'b1);

    // R8: idle toggling with start low
    begin
      logic [15:0] keep;
      keep = result;
      for (int i = 0; i < 6; i++) begin
        mode = 1'($urandom); operand = 16'($urandom);
        @(negedge clk);
        chk("R8", "done idle", int'(done), 0);
        chk("R8", "result idle", int'(result), int'(keep));
      end
    end

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic m;
      m = (($urandom % 5) == 0);
      issue(m, 16'($urandom), (($urandom % 4) == 0) && !m);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule